// File: doc/BRIEF.md
# Bus Slave Local Access Sequencer

This block runs the local side of a transfer once the board has been selected as a slave on a synchronous, multiplexed backplane bus. When a cycle starts with a matching address, the sequencer records whether the cycle is a read or a write, and whether it is a block write. It then uses a handshake with local logic to produce the local strobes. Local logic grants access with an active-low grant. It paces the data words of a block write with an active-low interim acknowledge. It closes the transfer with an active-low local acknowledge.

Every register in the block updates on the bus sample edge, which is the rising edge of `clk` here. Each output is registered, so it changes on the first sample edge that sees the input condition causing the change. The address enable and the data enable follow the grant. On a block write, the data-load clock gives a two-cycle first pulse, then one-cycle pulses on interim acknowledges, then a final pulse on the local acknowledge. On a read, the bus drive enable goes active for the acknowledge cycle. A transaction ends on the first sample edge after the acknowledge at which the grant is released.

Top module: `slave_access_seq`

## Requirements
- R1: While `rst` is high and on the first edge after it, `laddr_en_n`=1, `ldata_clk`=0, `ldata_en_n`=1 and `bus_drv_n`=1.
- R2: A start sampled with `addr_match`=0 is ignored. All four outputs stay inactive and later grant, interim or local acknowledges have no effect until a matching start is sampled.
- R3: While selected, `laddr_en_n` equals the `grant_n` value sampled on the previous edge. This includes the start edge itself, so a grant that is already low at start drives the enable low on that edge.
- R4: `ldata_en_n` goes low on the first edge that samples the grant low during a write. It returns high on the first edge that samples the grant high. On reads it stays high.
- R5: On a single write, an edge that samples `lack_n`=0 with the grant low raises `ldata_clk` for exactly one cycle.
- R6: On a block write, the edge that first samples the grant low (or the start edge, if the grant is already low) raises `ldata_clk` for exactly two cycles.
- R7: On a block write, words 2 to BLOCK_WORDS-1 each start with an edge that samples `iack_n`=0 while `ldata_clk` is low. That edge raises `ldata_clk` for one cycle, even if `iack_n` stays low. An interim acknowledge is ignored while `ldata_clk` is high, and after BLOCK_WORDS-1 pulses have been given.
- R8: On a block write, the local acknowledge is accepted only after BLOCK_WORDS-1 pulses have been given, and it then makes the final one-cycle pulse. An earlier local acknowledge is ignored. The default is BLOCK_WORDS=4.
- R9: On a read, an edge that samples `lack_n`=0 with the grant low drives `bus_drv_n` low for exactly one cycle. `ldata_clk` stays low for the whole read.
- R10: Only one local acknowledge is accepted per transaction; later ones produce no pulse. The transaction ends, and all outputs return inactive, on the first edge after acceptance that samples the grant high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the rising edge is the sample edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_start | input | 1 | Start cycle indication, one cycle wide |
| addr_match | input | 1 | Address decode hit, valid with `bus_start` |
| xfer_write | input | 1 | 1 = write, 0 = read; sampled at start |
| xfer_block | input | 1 | 1 = block write; sampled at start |
| grant_n | input | 1 | Active-low access grant from local logic |
| iack_n | input | 1 | Active-low interim acknowledge from local logic |
| lack_n | input | 1 | Active-low local acknowledge |
| laddr_en_n | output | 1 | Active-low local address enable |
| ldata_clk | output | 1 | Local data-load clock, active high |
| ldata_en_n | output | 1 | Active-low local data enable |
| bus_drv_n | output | 1 | Active-low bus drive enable for the read acknowledge |

## Verification
The assertions assume that `bus_start` lasts one cycle and never arrives while a transaction is open. They also assume that local logic releases the grant only after it has acknowledged. Under those assumptions, every pulse ends within two cycles and the outputs are quiet whenever nothing is selected. The stimulus is a set of scripted transactions that each start from idle: an early grant, a late grant, a grant that is withdrawn and given again, a held interim acknowledge, and premature and repeated acknowledges. Each transaction is closed by releasing the grant before the next one begins.

// File: rtl/slsq_pkg.sv
package slsq_pkg;
  typedef struct packed {
    logic wr;
    logic blk;
  } xfer_mode_t;

  localparam xfer_mode_t MODE_NONE = '{wr: 1'b0, blk: 1'b0};
endpackage

// File: rtl/slsq_select.sv
module slsq_select
  import slsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic       addr_hit,
  input  logic       is_write,
  input  logic       is_block,
  input  logic       grant,
  input  logic       ack_take,
  output logic       fresh,
  output logic       sel_now,
  output xfer_mode_t mode_now,
  output logic       acked_now,
  output logic       sel_q
);
  xfer_mode_t mode_q;
  logic       acked_q;
  logic       finishing;

  always_comb begin
    fresh     = !sel_q && start && addr_hit;
    sel_now   = sel_q || fresh;
    mode_now  = fresh ? '{wr: is_write, blk: is_block} : mode_q;
    acked_now = fresh ? 1'b0 : acked_q;
    finishing = sel_q && acked_q && !grant;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      mode_q  <= MODE_NONE;
      acked_q <= 1'b0;
    end else if (fresh) begin
      sel_q   <= 1'b1;
      mode_q  <= '{wr: is_write, blk: is_block};
      acked_q <= ack_take;
    end else if (finishing) begin
      sel_q   <= 1'b0;
      mode_q  <= MODE_NONE;
      acked_q <= 1'b0;
    end else if (ack_take) begin
      acked_q <= 1'b1;
    end
  end

  // R10: an acknowledge is taken at most once per transaction
  assert_ack_once_R10: assert property (@(posedge clk) disable iff (rst)
    (sel_q && acked_q) |-> !ack_take);
endmodule

// File: rtl/slsq_dload.sv
module slsq_dload
  import slsq_pkg::*;
#(
  parameter int WORDS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fresh,
  input  logic       sel_now,
  input  xfer_mode_t mode_now,
  input  logic       acked_now,
  input  logic       grant,
  input  logic       iack_n,
  input  logic       lack_n,
  output logic       ack_take,
  output logic       dclk
);
  localparam int CNT_W = $clog2(WORDS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic [CNT_W-1:0] words_q, words_eff;
  logic             hold_q;
  logic             blk_wr, idle, first_go, mid_go, last_ready, dclk_set;

  always_comb begin
    words_eff  = fresh ? '0 : words_q;
    blk_wr     = sel_now && mode_now.wr && mode_now.blk && grant;
    idle       = !dclk;
    first_go   = blk_wr && idle && (words_eff == '0);
    mid_go     = blk_wr && idle && !acked_now && !iack_n &&
                 (words_eff != '0) && (words_eff < LAST);
    last_ready = !(mode_now.wr && mode_now.blk) || (words_eff == LAST);
    ack_take   = sel_now && grant && idle && !acked_now && !lack_n && last_ready;
    dclk_set   = first_go || mid_go || (ack_take && mode_now.wr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dclk    <= 1'b0;
      hold_q  <= 1'b0;
      words_q <= '0;
    end else begin
      if (dclk && hold_q) begin
        dclk   <= 1'b1;
        hold_q <= 1'b0;
      end else begin
        dclk   <= dclk_set;
        hold_q <= first_go;
      end
      if (!sel_now)
        words_q <= '0;
      else if (dclk_set)
        words_q <= words_eff + CNT_W'(1);
      else
        words_q <= words_eff;
    end
  end

  // R6: no load pulse lasts longer than two cycles
  assert_pulse_width_R6: assert property (@(posedge clk) disable iff (rst)
    (dclk && $past(dclk)) |=> !dclk);
  // R7: word counter never passes the block length
  assert_word_bound_R7: assert property (@(posedge clk) disable iff (rst)
    words_q <= CNT_W'(WORDS));
endmodule

// File: rtl/slsq_strobes.sv
module slsq_strobes
  import slsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sel_now,
  input  xfer_mode_t mode_now,
  input  logic       grant,
  input  logic       ack_take,
  output logic       aen_n,
  output logic       den_n,
  output logic       drv_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      aen_n <= 1'b1;
      den_n <= 1'b1;
      drv_n <= 1'b1;
    end else begin
      aen_n <= !(sel_now && grant);
      den_n <= !(sel_now && mode_now.wr && grant);
      drv_n <= !(ack_take && !mode_now.wr);
    end
  end

  // R4: data enable only ever appears together with address enable
  assert_den_within_aen_R4: assert property (@(posedge clk) disable iff (rst)
    !den_n |-> !aen_n);
  // R9: bus drive lasts one cycle
  assert_drv_single_R9: assert property (@(posedge clk) disable iff (rst)
    !drv_n |=> drv_n);
endmodule

// File: rtl/slave_access_seq.sv
module slave_access_seq
  import slsq_pkg::*;
#(
  parameter int BLOCK_WORDS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_start,
  input  logic addr_match,
  input  logic xfer_write,
  input  logic xfer_block,
  input  logic grant_n,
  input  logic iack_n,
  input  logic lack_n,
  output logic laddr_en_n,
  output logic ldata_clk,
  output logic ldata_en_n,
  output logic bus_drv_n
);
  logic       grant, fresh, sel_now, acked_now, sel_q, ack_take;
  xfer_mode_t mode_now;

  assign grant = !grant_n;

  slsq_select u_select (
    .clk(clk), .rst(rst), .start(bus_start), .addr_hit(addr_match),
    .is_write(xfer_write), .is_block(xfer_block), .grant(grant),
    .ack_take(ack_take), .fresh(fresh), .sel_now(sel_now),
    .mode_now(mode_now), .acked_now(acked_now), .sel_q(sel_q)
  );

  slsq_dload #(.WORDS(BLOCK_WORDS)) u_dload (
    .clk(clk), .rst(rst), .fresh(fresh), .sel_now(sel_now),
    .mode_now(mode_now), .acked_now(acked_now), .grant(grant),
    .iack_n(iack_n), .lack_n(lack_n), .ack_take(ack_take), .dclk(ldata_clk)
  );

  slsq_strobes u_strobes (
    .clk(clk), .rst(rst), .sel_now(sel_now), .mode_now(mode_now),
    .grant(grant), .ack_take(ack_take), .aen_n(laddr_en_n),
    .den_n(ldata_en_n), .drv_n(bus_drv_n)
  );

  // R2: nothing selected means every output is quiet
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !sel_q |-> (laddr_en_n && ldata_en_n && !ldata_clk && bus_drv_n));
  // R9: no load clock alongside the read drive
  assert_drv_no_dclk_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_drv_n |-> !ldata_clk);
endmodule

// File: tb/slave_access_seq_tb.sv
module slave_access_seq_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_start = 0, addr_match = 0, xfer_write = 0, xfer_block = 0;
  logic grant_n = 1, iack_n = 1, lack_n = 1;
  logic laddr_en_n, ldata_clk, ldata_en_n, bus_drv_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  localparam logic [3:0] QUIET = 4'b1011; // {aen_n, dclk, den_n, drv_n}

  always #5 clk = ~clk;

  slave_access_seq u_dut (
    .clk(clk), .rst(rst), .bus_start(bus_start), .addr_match(addr_match),
    .xfer_write(xfer_write), .xfer_block(xfer_block), .grant_n(grant_n),
    .iack_n(iack_n), .lack_n(lack_n), .laddr_en_n(laddr_en_n),
    .ldata_clk(ldata_clk), .ldata_en_n(ldata_en_n), .bus_drv_n(bus_drv_n)
  );

  // Driver: applies inputs for one edge and queues the outputs expected after it
  task automatic step(input logic s, h, w, b, g, i, l,
                      input logic [3:0] e, input string tag);
    @(negedge clk);
    bus_start = s; addr_match = h; xfer_write = w; xfer_block = b;
    grant_n = g; iack_n = i; lack_n = l;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares outputs just after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [3:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {laddr_en_n, ldata_clk, ldata_en_n, bus_drv_n};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: outputs {aen_n,dclk,den_n,drv_n} actual %b expected %b at %0t",
                   t, a, e, $time);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset
    step(0,0,0,0,1,1,1, QUIET, "R1");
    step(0,0,0,0,0,0,0, QUIET, "R1");
    rst = 1'b0;
    step(0,0,0,0,1,1,1, QUIET, "R1");

    // R2 mismatching start ignored
    step(1,0,1,1,0,0,0, QUIET, "R2");
    step(0,0,0,0,0,0,0, QUIET, "R2");
    step(0,0,0,0,0,1,0, QUIET, "R2");
    step(0,0,0,0,1,1,1, QUIET, "R2");

    // Single write, late grant: R3 R4 R5 R10
    step(1,1,1,0,1,1,1, QUIET,   "R3");
    step(0,0,0,0,1,1,1, QUIET,   "R3");
    step(0,0,0,0,0,1,1, 4'b0001, "R4");
    step(0,0,0,0,0,1,0, 4'b0101, "R5");
    step(0,0,0,0,0,1,1, 4'b0001, "R5");
    step(0,0,0,0,0,1,0, 4'b0001, "R10");
    step(0,0,0,0,1,1,1, QUIET,   "R10");
    step(0,0,0,0,1,1,1, QUIET,   "R10");

    // Block write, grant early during start: R3 R6 R7 R8
    step(1,1,1,1,0,1,1, 4'b0101, "R6");
    step(0,0,0,0,0,0,1, 4'b0101, "R6");
    step(0,0,0,0,0,1,1, 4'b0001, "R6");
    step(0,0,0,0,0,0,1, 4'b0101, "R7");
    step(0,0,0,0,0,0,1, 4'b0001, "R7");
    step(0,0,0,0,0,0,1, 4'b0101, "R7");
    step(0,0,0,0,0,0,1, 4'b0001, "R7");
    step(0,0,0,0,0,0,1, 4'b0001, "R7");
    step(0,0,0,0,0,1,0, 4'b0101, "R8");
    step(0,0,0,0,0,1,1, 4'b0001, "R8");
    step(0,0,0,0,1,1,1, QUIET,   "R10");

    // Block write, grant late; early local acknowledge ignored: R6 R7 R8
    step(1,1,1,1,1,1,1, QUIET,   "R6");
    step(0,0,0,0,1,1,1, QUIET,   "R6");
    step(0,0,0,0,0,1,1, 4'b0101, "R6");
    step(0,0,0,0,0,1,1, 4'b0101, "R6");
    step(0,0,0,0,0,1,0, 4'b0001, "R8");
    step(0,0,0,0,0,0,1, 4'b0101, "R7");
    step(0,0,0,0,0,1,1, 4'b0001, "R7");
    step(0,0,0,0,0,0,1, 4'b0101, "R7");
    step(0,0,0,0,0,1,1, 4'b0001, "R7");
    step(0,0,0,0,0,1,0, 4'b0101, "R8");
    step(0,0,0,0,0,1,1, 4'b0001, "R8");
    step(0,0,0,0,1,1,1, QUIET,   "R10");

    // Read, grant early, withdrawn and regranted: R3 R4 R9 R10
    step(1,1,0,0,0,1,1, 4'b0011, "R3");
    step(0,0,0,0,0,1,1, 4'b0011, "R4");
    step(0,0,0,0,1,1,1, QUIET,   "R3");
    step(0,0,0,0,0,1,1, 4'b0011, "R3");
    step(0,0,0,0,0,0,0, 4'b0010, "R9");
    step(0,0,0,0,0,1,0, 4'b0011, "R9");
    step(0,0,0,0,1,1,1, QUIET,   "R10");
    step(0,0,0,0,1,1,1, QUIET,   "R10");

    step(0,0,0,0,1,1,1, QUIET, "R2");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule